// File: doc/BRIEF.md
# Interrupt Stack Switch Frame Builder

This block performs the stack half of interrupt entry. When a request arrives, it picks the stack the handler will run on. A nonzero 3-bit table index selects one of seven alternate stack pointers, and that switch happens whether or not the privilege level changes. An index of zero falls back to a per-privilege-level table when the privilege changes, or keeps the current stack pointer when it does not.

It then writes the interrupted context to that stack, one word per memory handshake, going downward. The order is the old stack selector, the old stack pointer, the flags, the code selector and the instruction pointer, followed by the error code when one is supplied. When the last word is written, it pulses done and presents the final stack pointer and the new stack selector. The new selector is null except that its requested-privilege field carries the new privilege level.

Two slot formats exist. The wide format uses 8-byte slots and first aligns the chosen stack down to 16 bytes. The narrow format uses 4-byte slots, does no alignment and writes only the low 32 bits of each value. Software fills both pointer tables through simple indexed write ports.

Top module: `intr_frame_builder`

## Requirements
- R1: For a request with `req_ist` from 1 to 7, the stack base is alternate-table entry `req_ist`.
- R2: For `req_ist` = 0, the base is legacy-table entry `req_cpl` when `req_pl_change` = 1. Otherwise the base is `old_sp`.
- R3: A nonzero `req_ist` selects the alternate entry even when `req_pl_change` = 0, and the legacy table is then not used.
- R4: With done, `new_ss` carries `req_cpl` in bits [1:0] and zero in bits [15:2].
- R5: The writes go in this order: slot 0 old SS, slot 1 old SP, slot 2 flags, slot 3 CS, slot 4 IP, and slot 5 the error code, which is written only when `req_has_err` = 1. This gives 6 or 5 writes. The 16-bit selectors are zero-extended.
- R6: With `req_wide` = 1, the base is rounded down to a multiple of 16 and the slots are 8 bytes. Write k (counting from 0) goes to base − 8·(k+1).
- R7: With `req_wide` = 0, the base is not aligned and the slots are 4 bytes. Write k goes to base − 4·(k+1), and bits [63:32] of each data word are zero.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values. Each handshake advances exactly one slot.
- R9: `done` is high for exactly one cycle: the cycle after the last handshake. In that cycle, `final_sp` equals the address of the last write.
- R10: After reset, `busy`, `mem_valid` and `done` are low. A `req_valid` seen while `busy` is high is dropped, and no frame follows it.
- R11: An alternate-table write with index 1 to 7 updates that entry. A write with index 0 changes no entry.
- R12: A legacy-table write with index 0 to 3 updates the entry used for that privilege level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt entry request, taken when idle |
| req_ist | input | 3 | Alternate stack index, 0 = legacy selection |
| req_cpl | input | 2 | New privilege level |
| req_pl_change | input | 1 | Privilege level changes on this entry |
| req_has_err | input | 1 | Push an error code |
| req_wide | input | 1 | 1 = 8-byte slots with alignment, 0 = 4-byte slots |
| old_ss | input | 16 | Interrupted stack selector |
| old_sp | input | 64 | Interrupted stack pointer |
| old_flags | input | 64 | Interrupted flags |
| old_cs | input | 16 | Interrupted code selector |
| old_ip | input | 64 | Interrupted instruction pointer |
| err_code | input | 64 | Error code value |
| alt_we | input | 1 | Alternate table write strobe |
| alt_idx | input | 3 | Alternate table write index |
| alt_wdata | input | 64 | Alternate table write data |
| pl_we | input | 1 | Legacy table write strobe |
| pl_idx | input | 2 | Legacy table write index |
| pl_wdata | input | 64 | Legacy table write data |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Write byte address |
| mem_data | output | 64 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| final_sp | output | 64 | Stack pointer after the frame |
| new_ss | output | 16 | New stack selector |

## Verification
Requests are sent with every alternate index from 1 to 7 and with index zero, both with and without a privilege change. These cases separate alternate selection, legacy-table selection and keeping the current pointer. In particular, a nonzero index with no privilege change exposes a design that consults the alternate table only when the privilege changes.

Frames with and without an error code, in both slot formats, are built on unaligned stack pointers. These tell apart the slot size, the alignment, the push order and the upper-half masking. A random ready pattern stretches the handshakes. Extra requests injected mid-frame, and a table write at index zero followed by frames on all seven entries, expose capture while busy and aliased table writes.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned SEL_W  = 16;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SEL_W-1:0]  sel_t;

  function automatic word_t slot_bytes(input logic wide);
    return wide ? word_t'(8) : word_t'(4);
  endfunction

  function automatic word_t align_sp(input word_t sp, input logic wide);
    return wide ? (sp & ~word_t'(15)) : sp;
  endfunction

  function automatic logic [2:0] frame_len(input logic has_err);
    return has_err ? 3'd6 : 3'd5;
  endfunction

  function automatic sel_t null_sel(input logic [1:0] cpl);
    return {{(SEL_W-2){1'b0}}, cpl};
  endfunction

  function automatic word_t frame_word(input logic [2:0] k, input sel_t ss,
                                       input word_t sp, input word_t fl,
                                       input sel_t cs, input word_t ip,
                                       input word_t err, input logic wide);
    word_t w;
    case (k)
      3'd0:    w = word_t'(ss);
      3'd1:    w = sp;
      3'd2:    w = fl;
      3'd3:    w = word_t'(cs);
      3'd4:    w = ip;
      default: w = err;
    endcase
    if (!wide) w = w & word_t'(64'h0000_0000_FFFF_FFFF);
    return w;
  endfunction
endpackage

// File: rtl/ifb_reg_table.sv
module ifb_reg_table
  import ifb_pkg::*;
#(
  parameter int DEPTH    = 7,
  parameter int IDX_W    = 3,
  parameter int BASE_IDX = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output word_t            rd_data
);
  word_t ent [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BASE_IDX + e);
    always_ff @(posedge clk) begin
      if (!rst_n)                        ent[e] <= '0;
      else if (we && (wr_idx == MY_IDX)) ent[e] <= wr_data;
    end

    // R11: a write aimed elsewhere (including index 0) leaves this entry alone
    a_r11_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (wr_idx != MY_IDX)) |=> $stable(ent[e]));
  end

  always_comb begin
    rd_data = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_idx == IDX_W'(BASE_IDX + e)) rd_data = ent[e];
    end
  end
endmodule

// File: rtl/ifb_stack_select.sv
module ifb_stack_select
  import ifb_pkg::*;
#(
  parameter int IST_W = 3,
  parameter int PL_W  = 2
) (
  input  logic [IST_W-1:0] ist,
  input  logic [PL_W-1:0]  cpl,
  input  logic             pl_change,
  input  logic             wide,
  input  word_t            cur_sp,
  input  word_t            alt_sp,
  input  word_t            pl_sp,
  output logic             use_alt,
  output logic             use_pl,
  output word_t            base_sp
);
  word_t raw_sp;

  assign use_alt = (ist != '0);
  assign use_pl  = !use_alt && pl_change;

  always_comb begin
    if (use_alt)     raw_sp = alt_sp;
    else if (use_pl) raw_sp = pl_sp;
    else             raw_sp = cur_sp;
    base_sp = align_sp(raw_sp, wide);
  end

  // R6: wide frames start on a 16-byte boundary
  always_comb begin
    if (wide) a_r6_base_aligned: assert (base_sp[3:0] == 4'h0);
  end

  // R3: alternate and legacy paths never both active; cpl only matters on legacy path
  always_comb begin
    a_r3_exclusive_paths: assert (!(use_alt && use_pl));
  end

  logic unused_cpl;
  assign unused_cpl = ^cpl;
endmodule

// File: rtl/ifb_push_seq.sv
module ifb_push_seq
  import ifb_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  word_t           base_sp,
  input  logic [PL_W-1:0] cpl,
  input  logic            has_err,
  input  logic            wide,
  input  sel_t            in_ss,
  input  word_t           in_sp,
  input  word_t           in_fl,
  input  sel_t            in_cs,
  input  word_t           in_ip,
  input  word_t           in_err,
  input  logic            mem_ready,
  output logic            mem_valid,
  output word_t           mem_addr,
  output word_t           mem_data,
  output logic            busy,
  output logic            done,
  output word_t           final_sp,
  output sel_t            new_ss
);
  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_FIN} st_t;
  st_t st;

  logic [2:0]      cnt;
  word_t           cur_addr;
  sel_t            ss_q, cs_q;
  word_t           sp_q, fl_q, ip_q, err_q;
  logic            wide_q, err_en_q;
  logic [PL_W-1:0] cpl_q;

  logic hs, last_hs;
  assign hs      = (st == S_PUSH) && mem_ready;
  assign last_hs = hs && (cnt == frame_len(err_en_q) - 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      cur_addr <= '0;
      ss_q     <= '0;
      cs_q     <= '0;
      sp_q     <= '0;
      fl_q     <= '0;
      ip_q     <= '0;
      err_q    <= '0;
      wide_q   <= 1'b0;
      err_en_q <= 1'b0;
      cpl_q    <= '0;
      final_sp <= '0;
      new_ss   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_PUSH;
          cnt      <= '0;
          cur_addr <= base_sp - slot_bytes(wide);
          ss_q     <= in_ss;
          cs_q     <= in_cs;
          sp_q     <= in_sp;
          fl_q     <= in_fl;
          ip_q     <= in_ip;
          err_q    <= in_err;
          wide_q   <= wide;
          err_en_q <= has_err;
          cpl_q    <= cpl;
        end
        S_PUSH: if (hs) begin
          cnt      <= cnt + 3'd1;
          cur_addr <= cur_addr - slot_bytes(wide_q);
          if (last_hs) begin
            st       <= S_FIN;
            final_sp <= cur_addr;
            new_ss   <= null_sel(2'(cpl_q));
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_valid = (st == S_PUSH);
  assign mem_addr  = cur_addr;
  assign mem_data  = frame_word(cnt, ss_q, sp_q, fl_q, cs_q, ip_q, err_q, wide_q);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);

  a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !last_hs) |=> (mem_addr == $past(mem_addr) - slot_bytes(wide_q)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_final_is_last_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (final_sp == $past(mem_addr)));

  a_r4_null_selector: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_ss[SEL_W-1:2] == '0));

  a_r10_no_capture_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ip_q) && $stable(ss_q) && $stable(err_en_q) && $stable(wide_q)));
endmodule

// File: rtl/intr_frame_builder.sv
module intr_frame_builder
  import ifb_pkg::*;
#(
  parameter int ALT_N = 7,
  parameter int PL_N  = 4,
  parameter int IST_W = 3,
  parameter int PL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IST_W-1:0] req_ist,
  input  logic [PL_W-1:0]  req_cpl,
  input  logic             req_pl_change,
  input  logic             req_has_err,
  input  logic             req_wide,
  input  logic [15:0]      old_ss,
  input  logic [63:0]      old_sp,
  input  logic [63:0]      old_flags,
  input  logic [15:0]      old_cs,
  input  logic [63:0]      old_ip,
  input  logic [63:0]      err_code,
  input  logic             alt_we,
  input  logic [IST_W-1:0] alt_idx,
  input  logic [63:0]      alt_wdata,
  input  logic             pl_we,
  input  logic [PL_W-1:0]  pl_idx,
  input  logic [63:0]      pl_wdata,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [63:0]      mem_addr,
  output logic [63:0]      mem_data,
  output logic             busy,
  output logic             done,
  output logic [63:0]      final_sp,
  output logic [15:0]      new_ss
);
  word_t alt_rd, pl_rd, base_sp;
  logic  use_alt, use_pl, start;

  assign start = req_valid && !busy;

  ifb_reg_table #(.DEPTH(ALT_N), .IDX_W(IST_W), .BASE_IDX(1)) u_alt_tbl (
    .clk(clk), .rst_n(rst_n), .we(alt_we), .wr_idx(alt_idx), .wr_data(alt_wdata),
    .rd_idx(req_ist), .rd_data(alt_rd)
  );

  ifb_reg_table #(.DEPTH(PL_N), .IDX_W(PL_W), .BASE_IDX(0)) u_pl_tbl (
    .clk(clk), .rst_n(rst_n), .we(pl_we), .wr_idx(pl_idx), .wr_data(pl_wdata),
    .rd_idx(req_cpl), .rd_data(pl_rd)
  );

  ifb_stack_select #(.IST_W(IST_W), .PL_W(PL_W)) u_sel (
    .ist(req_ist), .cpl(req_cpl), .pl_change(req_pl_change), .wide(req_wide),
    .cur_sp(old_sp), .alt_sp(alt_rd), .pl_sp(pl_rd),
    .use_alt(use_alt), .use_pl(use_pl), .base_sp(base_sp)
  );

  ifb_push_seq #(.PL_W(PL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_sp(base_sp), .cpl(req_cpl),
    .has_err(req_has_err), .wide(req_wide),
    .in_ss(old_ss), .in_sp(old_sp), .in_fl(old_flags), .in_cs(old_cs),
    .in_ip(old_ip), .in_err(err_code),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .done(done),
    .final_sp(final_sp), .new_ss(new_ss)
  );

  // R2: on a legacy path with privilege change the base comes from the level table
  a_r2_legacy_base: assert property (@(posedge clk) disable iff (!rst_n)
    (start && use_pl && !req_wide) |-> (base_sp == pl_rd));

  // R1: nonzero index in narrow format starts from the alternate entry as-is
  a_r1_alt_base: assert property (@(posedge clk) disable iff (!rst_n)
    (start && use_alt && !req_wide) |-> (base_sp == alt_rd));
endmodule

// File: tb/sim_intr_frame_builder.sv
`timescale 1ns/1ps
module sim_intr_frame_builder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_pl_change = 0, req_has_err = 0, req_wide = 0;
  logic [2:0]  req_ist = 0;
  logic [1:0]  req_cpl = 0;
  logic [15:0] old_ss = 0, old_cs = 0;
  logic [63:0] old_sp = 0, old_flags = 0, old_ip = 0, err_code = 0;
  logic        alt_we = 0, pl_we = 0, mem_ready = 0;
  logic [2:0]  alt_idx = 0;
  logic [1:0]  pl_idx = 0;
  logic [63:0] alt_wdata = 0, pl_wdata = 0;
  logic        mem_valid, busy, done;
  logic [63:0] mem_addr, mem_data, final_sp;
  logic [15:0] new_ss;

  int checks = 0, errors = 0;
  logic [63:0] alt_m [8];
  logic [63:0] pl_m [4];

  always #2.5 clk = ~clk;

  intr_frame_builder u0 (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_base(input logic [2:0] ist, input logic [1:0] cpl,
                                           input bit chg, input bit wide, input logic [63:0] sp);
    logic [63:0] b;
    b = (ist != 0) ? alt_m[ist] : (chg ? pl_m[cpl] : sp);
    if (wide) b = {b[63:4], 4'b0000};
    return b;
  endfunction

  function automatic logic [63:0] exp_word(input int k, input bit wide);
    logic [63:0] v;
    v = (k == 0) ? {48'd0, old_ss} : (k == 1) ? old_sp : (k == 2) ? old_flags :
        (k == 3) ? {48'd0, old_cs} : (k == 4) ? old_ip : err_code;
    if (!wide) v[63:32] = 32'd0;
    return v;
  endfunction

  task automatic wr_alt(input logic [2:0] i, input logic [63:0] d);
    @(negedge clk); alt_we = 1; alt_idx = i; alt_wdata = d;
    @(negedge clk); alt_we = 0;
    if (i != 0) alt_m[i] = d;
  endtask

  task automatic wr_pl(input logic [1:0] i, input logic [63:0] d);
    @(negedge clk); pl_we = 1; pl_idx = i; pl_wdata = d;
    @(negedge clk); pl_we = 0;
    pl_m[i] = d;
  endtask

  task automatic run_frame(input logic [2:0] ist, input logic [1:0] cpl, input bit chg,
                           input bit herr, input bit wide, input bit inject, input string rq);
    logic [63:0] base, slot, exp_a;
    int k = 0, n, guard = 0;
    bit fin = 0;
    @(negedge clk);
    req_ist = ist; req_cpl = cpl; req_pl_change = chg; req_has_err = herr; req_wide = wide;
    old_ss = 16'($urandom); old_cs = 16'($urandom);
    old_sp = {$urandom, $urandom}; old_flags = {$urandom, $urandom};
    old_ip = {$urandom, $urandom}; err_code = {$urandom, $urandom};
    base = exp_base(ist, cpl, chg, wide, old_sp);
    slot = wide ? 64'd8 : 64'd4;
    n = herr ? 6 : 5;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!fin && guard < 300) begin
      guard++;
      if (done) begin
        chk(k == n, "R5 write count", 64'(k), 64'(n));
        chk(final_sp == base - slot * 64'(n), "R9 final_sp", final_sp, base - slot * 64'(n));
        chk(new_ss == {14'd0, cpl}, "R4 new_ss", {48'd0, new_ss}, {62'd0, cpl});
        fin = 1;
        req_valid = 0; mem_ready = 0;
      end else begin
        mem_ready = mem_valid && ($urandom % 3 != 0);
        if (mem_valid && mem_ready) begin
          exp_a = base - slot * 64'(k + 1);
          chk(mem_addr == exp_a, wide ? "R6 addr" : "R7 addr", mem_addr, exp_a);
          chk(mem_data == exp_word(k, wide), {rq, " R5 data"}, mem_data, exp_word(k, wide));
          k++;
        end
        if (inject && k == 2) begin
          req_valid = 1; req_ist = 3'($urandom); req_has_err = ~herr; req_wide = ~wide;
        end
        @(negedge clk);
      end
    end
    chk(fin, "R9 done seen", 64'(fin), 64'd1);
    @(negedge clk);
    chk(!done && !mem_valid && !busy, "R10 idle after frame",
        {61'd0, done, mem_valid, busy}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 8; i++) alt_m[i] = 0;
    for (int i = 0; i < 4; i++) pl_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_valid && !busy && !done, "R10 reset state", {61'd0, mem_valid, busy, done}, 64'd0);
    for (int i = 1; i < 8; i++) wr_alt(3'(i), {$urandom, $urandom} | 64'h7);
    for (int i = 0; i < 4; i++) wr_pl(2'(i), {$urandom, $urandom} | 64'h3);  // R12
    // directed cases
    run_frame(3'd3, 2'd0, 0, 1, 1, 0, "R3 alt no change");
    run_frame(3'd7, 2'd2, 1, 0, 1, 0, "R1 alt top entry");
    run_frame(3'd0, 2'd1, 1, 1, 1, 0, "R2 legacy table");
    run_frame(3'd0, 2'd3, 0, 0, 1, 0, "R2 keep sp");
    run_frame(3'd1, 2'd3, 1, 1, 0, 0, "R7 narrow err");
    run_frame(3'd0, 2'd2, 0, 0, 0, 0, "R7 narrow keep");
    run_frame(3'd5, 2'd1, 1, 1, 1, 1, "R10 inject busy");
    wr_pl(2'd2, 64'h0000_1234_5678_9ABF);
    run_frame(3'd0, 2'd2, 1, 0, 0, 0, "R12 updated entry");
    // R11: index-0 write must not disturb entries 1..7
    wr_alt(3'd0, 64'hDEAD_BEEF_0BAD_F00D);
    for (int i = 1; i < 8; i++) run_frame(3'(i), 2'd0, 0, 0, 0, 0, "R11 after idx0 write");
    // random mix
    for (int t = 0; t < 40; t++) begin
      if (t % 8 == 0) wr_alt(3'($urandom), {$urandom, $urandom});
      run_frame(3'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 4 == 0), "R1 R2 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule